// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block watches the command and address pins of a single-rank DDR SDRAM and classifies each clocked command. It reports the command as a one-hot vector in the same cycle. It keeps a registered picture of the device: which banks hold an open row, the burst length held in the base mode register, the output drive and DLL settings held in the extended mode register, and whether the device is in self refresh. It uses that picture to judge whether each command is legal. Each kind of rule violation sets its own sticky error bit.

Two state machines carry the sequencing. The power machine has two states. It moves from RUN to SELF on a refresh command issued with clock enable low, and from SELF back to RUN in the first cycle clock enable is high. That return counts as a DLL re-enable. The burst machine has five states: IDLE, READ, READ_AP, WRITE and WRITE_AP. A read or write command enters the matching state, and the auto-precharge request picks the _AP variant. The machine returns to IDLE when the burst counter expires or when a burst terminate arrives during a plain READ. A new read or write arriving in any state restarts the burst in the state that command selects. While a write burst runs, the block also turns the per-lane data mask into per-lane write enables.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With cs_n high, cmd_onehot is 1 (bit 0, no operation), whatever the other pins. With cs_n low, {ras_n,cas_n,we_n} maps to a bit: 111→bit 0, 011 activate→bit 1, 101 read→bit 2, 100 write→bit 3, 110 burst terminate→bit 4, 010 precharge→bit 5, 001 with cke high→bit 6 (auto refresh), 001 with cke low→bit 7 (self refresh entry), 000 load mode→bit 8.
- R2: An activate with cke high sets bank_open[ba] on the following cycle.
- R3: A precharge with addr[10] low clears only bank_open[ba]. With addr[10] high it clears every bank, whatever ba holds.
- R4: A read or write to a bank whose bank_open bit is clear sets err_flags[4].
- R5: A load mode command with ba = 0 writes the burst code from addr[2:0]. With ba = 1 it writes the extended register: dll_on becomes the inverse of addr[0], and drive_reduced becomes addr[1]. With ba = 2 or 3 it sets err_flags[0]. dll_on is 0 after reset.
- R6: A load of the extended register while any bank is open or any burst is running sets err_flags[1].
- R7: A read sets err_flags[2] if dll_on is 0, or if it comes fewer than DLL_WAIT (200) cycles after the last DLL enable. A DLL enable is an extended load with addr[0] = 0, or a self-refresh exit while dll_on is 1. A read exactly DLL_WAIT cycles later is legal.
- R8: burst_active is high for L cycles starting in the cycle after a read or write. L is 1, 2 or 4 for burst codes 1, 2 or 3, and 1 for any other code. The code after reset is 1.
- R9: A burst terminate during a plain read burst ends that burst in the next cycle. During a write burst, an auto-precharge read burst or no burst, it sets err_flags[3].
- R10: A read or write with addr[10] high leaves its bank open for the whole burst. The bank's bank_open bit clears in the cycle after the burst's last cycle.
- R11: During a write burst, lane_wr_en equals the inverse of dm (dm high blocks that lane). At all other times lane_wr_en is 0.
- R12: Any command other than no operation or self-refresh entry, given with cke low, sets err_flags[5] and changes no state. While in self refresh, cmd_onehot reads 1 and the pins have no effect until cke returns high.
- R13: err_flags bits stay set until err_clr is high at a clock edge, which clears them. A violation in the same cycle as err_clr still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_clr | input | 1 | Clears all error flags at the edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W (2) | Bank address |
| addr | input | ADDR_W (13) | Row, column or mode code |
| dm | input | NUM_LANES (8) | Write mask per byte lane |
| cmd_onehot | output | 9 | Decoded command, one-hot |
| err_flags | output | 6 | Sticky violation flags |
| bank_open | output | NUM_BANKS (4) | Row open per bank |
| burst_active | output | 1 | A burst is in progress |
| lane_wr_en | output | NUM_LANES (8) | Byte lanes written this cycle |
| dll_on | output | 1 | DLL enabled per extended register |
| drive_reduced | output | 1 | Reduced output drive selected |

## Verification
The assertions assume the pins are never unknown after reset, and that ba and addr are stable, valid values in any cycle whose command uses them. The bench meets this by driving every pin on the falling edge from defined values. It holds cke high through the random phase, so the monitor never leaves RUN while the random codes run. The assertion that ties an early read to the DLL flag assumes the extended load and the read come in consecutive cycles. The bench covers the full DLL_WAIT window with directed sequences instead.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    localparam int CMD_N = 9;
    localparam int ERR_N = 6;

    typedef enum logic [3:0] {
        C_NOP   = 4'd0,
        C_ACT   = 4'd1,
        C_READ  = 4'd2,
        C_WRITE = 4'd3,
        C_BST   = 4'd4,
        C_PRE   = 4'd5,
        C_AREF  = 4'd6,
        C_SREF  = 4'd7,
        C_LMR   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE     = 3'd0,
        B_READ     = 3'd1,
        B_READ_AP  = 3'd2,
        B_WRITE    = 3'd3,
        B_WRITE_AP = 3'd4
    } burst_e;

    typedef enum logic {
        P_RUN  = 1'b0,
        P_SELF = 1'b1
    } pwr_e;

    localparam int ERR_LMR_BANK = 0;
    localparam int ERR_EMR_BUSY = 1;
    localparam int ERR_EARLY_RD = 2;
    localparam int ERR_BST      = 3;
    localparam int ERR_CLOSED   = 4;
    localparam int ERR_CKE_LOW  = 5;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic hold_nop,
    output cmd_e cmd
);

    always_comb begin
        cmd = C_NOP;
        if (!cs_n && !hold_nop) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = C_NOP;
                3'b011: cmd = C_ACT;
                3'b101: cmd = C_READ;
                3'b100: cmd = C_WRITE;
                3'b110: cmd = C_BST;
                3'b010: cmd = C_PRE;
                3'b001: cmd = cke ? C_AREF : C_SREF;
                3'b000: cmd = C_LMR;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_req,
    input  logic [BANK_W-1:0]    open_idx,
    input  logic                 close_one,
    input  logic [BANK_W-1:0]    close_idx,
    input  logic                 close_all,
    input  logic                 close_ap,
    input  logic [BANK_W-1:0]    ap_idx,
    output logic [NUM_BANKS-1:0] open_vec
);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit_close;
        logic hit_open;

        always_comb begin
            hit_close = close_all
                     || (close_one && (close_idx == BANK_W'(i)))
                     || (close_ap  && (ap_idx    == BANK_W'(i)));
            hit_open  = open_req && (open_idx == BANK_W'(i));
        end

        always_ff @(posedge clk) begin
            if (!rst_n)          open_vec[i] <= 1'b0;
            else if (hit_close)  open_vec[i] <= 1'b0;
            else if (hit_open)   open_vec[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/ddr_burst_fsm.sv
module ddr_burst_fsm
    import ddr_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              want_ap,
    input  logic              stop_rd,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [CNT_W-1:0]  len,
    output burst_e            state,
    output logic              active,
    output logic              wr_phase,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank
);

    burst_e            st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BANK_W-1:0] bank_q;
    logic              last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            cnt    <= '0;
            bank_q <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (start_rd || start_wr) bank_q <= bank_in;
        end
    end

    // next state
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        ap_close = 1'b0;
        last     = (cnt == CNT_W'(1));
        if (st != B_IDLE) cnt_n = cnt - CNT_W'(1);
        unique case (st)
            B_IDLE: ;
            B_READ: begin
                if (stop_rd) begin
                    st_n  = B_IDLE;
                    cnt_n = '0;
                end else if (last) begin
                    st_n = B_IDLE;
                end
            end
            B_WRITE: if (last) st_n = B_IDLE;
            B_READ_AP, B_WRITE_AP: begin
                if (last) begin
                    st_n     = B_IDLE;
                    ap_close = 1'b1;
                end
            end
            default: st_n = B_IDLE;
        endcase
        if (start_rd || start_wr) begin
            // an interrupted auto-precharge burst still closes its bank
            if (st == B_READ_AP || st == B_WRITE_AP) ap_close = 1'b1;
            if (start_rd) st_n = want_ap ? B_READ_AP  : B_READ;
            else          st_n = want_ap ? B_WRITE_AP : B_WRITE;
            cnt_n = len;
        end
    end

    // outputs
    always_comb begin
        state    = st;
        active   = (st != B_IDLE);
        wr_phase = (st == B_WRITE) || (st == B_WRITE_AP);
        ap_bank  = bank_q;
    end

endmodule

// File: rtl/ddr_dll_timer.sv
module ddr_dll_timer #(
    parameter int WAIT = 200,
    localparam int CW  = $clog2(WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic turn_on,
    input  logic turn_off,
    input  logic restart,
    output logic dll_on,
    output logic ready
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_on <= 1'b0;
            cnt    <= '0;
        end else begin
            if (turn_off)     dll_on <= 1'b0;
            else if (turn_on) dll_on <= 1'b1;
            if (turn_on || restart)     cnt <= CW'(1);
            else if (cnt != CW'(WAIT))  cnt <= cnt + CW'(1);
        end
    end

    always_comb ready = dll_on && (cnt == CW'(WAIT));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int NUM_LANES = 8,
    parameter int DLL_WAIT  = 200,
    parameter int AP_BIT    = 10,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_clr,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BANK_W-1:0]    ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LANES-1:0] dm,
    output logic [CMD_N-1:0]     cmd_onehot,
    output logic [ERR_N-1:0]     err_flags,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 burst_active,
    output logic [NUM_LANES-1:0] lane_wr_en,
    output logic                 dll_on,
    output logic                 drive_reduced
);

    pwr_e   pwr, pwr_n;
    cmd_e   cmd;
    burst_e bst_state;
    logic   sr_exit;
    logic   act_go, rd_go, wr_go, bst_go, pre_go, lmr_go;
    logic   mr_ld, emr_ld, lmr_bad;
    logic   dll_ready, wr_phase, ap_close;
    logic [BANK_W-1:0]  ap_bank;
    logic [2:0]         bl_code;
    logic [CNT_W-1:0]   burst_len;
    logic [ERR_N-1:0]   err_new;

    ddr_cmd_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cke     (cke),
        .hold_nop(pwr == P_SELF),
        .cmd     (cmd)
    );

    // power state register
    always_ff @(posedge clk) begin
        if (!rst_n) pwr <= P_RUN;
        else        pwr <= pwr_n;
    end

    // power next state
    always_comb begin
        pwr_n   = pwr;
        sr_exit = 1'b0;
        unique case (pwr)
            P_RUN:  if (cmd == C_SREF) pwr_n = P_SELF;
            P_SELF: if (cke) begin
                pwr_n   = P_RUN;
                sr_exit = 1'b1;
            end
        endcase
    end

    // command qualifiers
    always_comb begin
        act_go  = cke && (cmd == C_ACT);
        rd_go   = cke && (cmd == C_READ);
        wr_go   = cke && (cmd == C_WRITE);
        bst_go  = cke && (cmd == C_BST);
        pre_go  = cke && (cmd == C_PRE);
        lmr_go  = cke && (cmd == C_LMR);
        mr_ld   = lmr_go && (ba == BANK_W'(0));
        emr_ld  = lmr_go && (ba == BANK_W'(1));
        lmr_bad = lmr_go && !mr_ld && !emr_ld;
    end

    ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_req (act_go),
        .open_idx (ba),
        .close_one(pre_go && !addr[AP_BIT]),
        .close_idx(ba),
        .close_all(pre_go && addr[AP_BIT]),
        .close_ap (ap_close),
        .ap_idx   (ap_bank),
        .open_vec (bank_open)
    );

    always_comb begin
        unique case (bl_code)
            3'd2:    burst_len = CNT_W'(2);
            3'd3:    burst_len = CNT_W'(4);
            default: burst_len = CNT_W'(1);
        endcase
    end

    ddr_burst_fsm #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_rd(rd_go),
        .start_wr(wr_go),
        .want_ap (addr[AP_BIT]),
        .stop_rd (bst_go),
        .bank_in (ba),
        .len     (burst_len),
        .state   (bst_state),
        .active  (burst_active),
        .wr_phase(wr_phase),
        .ap_close(ap_close),
        .ap_bank (ap_bank)
    );

    ddr_dll_timer #(.WAIT(DLL_WAIT)) u_dll (
        .clk     (clk),
        .rst_n   (rst_n),
        .turn_on (emr_ld && !addr[0]),
        .turn_off(emr_ld && addr[0]),
        .restart (sr_exit && dll_on),
        .dll_on  (dll_on),
        .ready   (dll_ready)
    );

    // mode register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_code       <= 3'd1;
            drive_reduced <= 1'b0;
        end else begin
            if (mr_ld)  bl_code       <= addr[2:0];
            if (emr_ld) drive_reduced <= addr[1];
        end
    end

    // violation detection
    always_comb begin
        err_new               = '0;
        err_new[ERR_LMR_BANK] = lmr_bad;
        err_new[ERR_EMR_BUSY] = emr_ld && ((|bank_open) || burst_active);
        err_new[ERR_EARLY_RD] = rd_go && !dll_ready;
        err_new[ERR_BST]      = bst_go && (bst_state != B_READ);
        err_new[ERR_CLOSED]   = (rd_go || wr_go) && !bank_open[ba];
        err_new[ERR_CKE_LOW]  = !cke && (cmd != C_NOP) && (cmd != C_SREF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_flags <= '0;
        else        err_flags <= (err_clr ? '0 : err_flags) | err_new;
    end

    always_comb begin
        cmd_onehot = CMD_N'(1) << cmd;
        lane_wr_en = wr_phase ? ~dm : '0;
    end

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int NUM_LANES = 8,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 err_clr,
    input logic                 cke,
    input logic [BANK_W-1:0]    ba,
    input logic [ADDR_W-1:0]    addr,
    input logic [CMD_N-1:0]     cmd_onehot,
    input logic [ERR_N-1:0]     err_flags,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 burst_active,
    input logic [NUM_LANES-1:0] lane_wr_en
);

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1); // R1

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_onehot[C_PRE] && cke && addr[10]) |=> (bank_open == '0)); // R3

    AST_BAD_LMR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_onehot[C_LMR] && cke && ba > BANK_W'(1)) |=> err_flags[ERR_LMR_BANK]); // R5

    AST_READ_RIGHT_AFTER_DLL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_onehot[C_LMR] && cke && ba == BANK_W'(1) && !addr[0])
         && cmd_onehot[C_READ] && cke) |=> err_flags[ERR_EARLY_RD]); // R7

    AST_LANES_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr_en != '0) |-> burst_active); // R11

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R13

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .NUM_LANES(NUM_LANES),
    .BANK_W   (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_clr     (err_clr),
    .cke         (cke),
    .ba          (ba),
    .addr        (addr),
    .cmd_onehot  (cmd_onehot),
    .err_flags   (err_flags),
    .bank_open   (bank_open),
    .burst_active(burst_active),
    .lane_wr_en  (lane_wr_en)
);

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;

    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_BST = 4'b0110;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_LMR = 4'b0000;
    localparam logic [12:0] AP   = 13'h0400;

    logic        clk = 1'b0;
    logic        rst_n, err_clr, cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [7:0]  dm;
    logic [8:0]  cmd_onehot;
    logic [5:0]  err_flags;
    logic [3:0]  bank_open;
    logic        burst_active;
    logic [7:0]  lane_wr_en;
    logic        dll_on, drive_reduced;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ddr_cmd_monitor uut (
        .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .dm(dm),
        .cmd_onehot(cmd_onehot), .err_flags(err_flags),
        .bank_open(bank_open), .burst_active(burst_active),
        .lane_wr_en(lane_wr_en), .dll_on(dll_on),
        .drive_reduced(drive_reduced)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] code, input logic ck,
                         input logic [1:0] b, input logic [12:0] a);
        @(negedge clk);
        err_clr = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = code;
        cke  = ck;
        ba   = b;
        addr = a;
        #1;
    endtask

    task automatic nop();
        issue(K_NOP, 1'b1, 2'd0, 13'd0);
    endtask

    task automatic clr_pulse();
        nop();
        err_clr = 1'b1;
    endtask

    function automatic logic [8:0] exp_oh(input logic [3:0] c, input logic ck);
        if (c[3]) return 9'd1;
        case (c[2:0])
            3'b111:  return 9'd1;
            3'b011:  return 9'd2;
            3'b101:  return 9'd4;
            3'b100:  return 9'd8;
            3'b110:  return 9'd16;
            3'b010:  return 9'd32;
            3'b001:  return ck ? 9'd64 : 9'd128;
            default: return 9'd256;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; err_clr = 1'b0; cke = 1'b1; dm = 8'h00;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = 2'd0; addr = 13'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 deselect after reset", cmd_onehot, 9'd1);
        chk("R13 flags clear after reset", err_flags, 0);
        chk("R2 banks idle after reset", bank_open, 0);
        chk("R5 dll off after reset", dll_on, 0);
        chk("R8 no burst after reset", burst_active, 0);

        // DLL enable, then a read one cycle too early
        issue(K_LMR, 1'b1, 2'd1, 13'h000);
        chk("R1 load mode decode", cmd_onehot, 9'd256);
        nop();
        chk("R5 dll enabled", dll_on, 1);
        chk("R5 drive normal", drive_reduced, 0);
        repeat (196) nop();
        issue(K_ACT, 1'b1, 2'd2, 13'd5);
        issue(K_RD, 1'b1, 2'd2, 13'd0);
        chk("R1 read decode", cmd_onehot, 9'd4);
        nop();
        chk("R7 read at 199 cycles flagged", err_flags, 6'h04);
        chk("R2 activate opens bank 2", bank_open, 4'h4);
        chk("R8 burst starts after read", burst_active, 1);
        clr_pulse();
        nop();
        chk("R13 clear pulse", err_flags, 0);
        issue(K_RD, 1'b1, 2'd2, 13'd0);
        nop();
        chk("R7 read after full wait legal", err_flags, 0);

        // burst length 4 clocks
        issue(K_LMR, 1'b1, 2'd0, 13'h003);
        nop();
        issue(K_RD, 1'b1, 2'd2, 13'd0);
        for (int k = 1; k <= 5; k++) begin
            nop();
            chk($sformatf("R8 long burst cycle %0d", k), burst_active, (k <= 4) ? 1 : 0);
        end

        // legal terminate
        issue(K_RD, 1'b1, 2'd2, 13'd0);
        issue(K_BST, 1'b1, 2'd0, 13'd0);
        chk("R1 terminate decode", cmd_onehot, 9'd16);
        nop();
        chk("R9 terminate ends read", burst_active, 0);
        chk("R9 terminate in read legal", err_flags, 0);

        // write mask and terminate during write
        dm = 8'hA5;
        issue(K_WR, 1'b1, 2'd2, 13'd0);
        chk("R11 no lanes before burst", lane_wr_en, 0);
        dm = 8'h0F;
        issue(K_BST, 1'b1, 2'd0, 13'd0);
        chk("R11 lanes from mask", lane_wr_en, 8'hF0);
        nop();
        chk("R9 terminate in write flagged", err_flags, 6'h08);
        clr_pulse();
        repeat (5) nop();
        dm = 8'h00;

        // auto precharge read
        issue(K_RD, 1'b1, 2'd2, AP);
        for (int k = 1; k <= 5; k++) begin
            nop();
            if (k == 4) chk("R10 bank open during ap burst", bank_open, 4'h4);
            if (k == 5) chk("R10 bank closed after ap burst", bank_open, 4'h0);
        end

        // write to closed bank
        issue(K_WR, 1'b1, 2'd2, 13'd0);
        nop();
        chk("R4 write to closed bank", err_flags, 6'h10);
        clr_pulse();
        repeat (5) nop();

        // precharge single and all
        issue(K_ACT, 1'b1, 2'd0, 13'd1);
        issue(K_ACT, 1'b1, 2'd3, 13'd1);
        nop();
        chk("R2 two banks open", bank_open, 4'h9);
        issue(K_PRE, 1'b1, 2'd3, 13'd0);
        nop();
        chk("R3 single precharge", bank_open, 4'h1);
        issue(K_ACT, 1'b1, 2'd3, 13'd1);
        issue(K_PRE, 1'b1, 2'd3, AP);
        nop();
        chk("R3 precharge all", bank_open, 4'h0);

        // extended load while a bank is open
        issue(K_ACT, 1'b1, 2'd1, 13'd1);
        issue(K_LMR, 1'b1, 2'd1, 13'h002);
        nop();
        chk("R6 extended load with open bank", err_flags, 6'h02);
        chk("R5 reduced drive stored", drive_reduced, 1);
        clr_pulse();
        issue(K_PRE, 1'b1, 2'd0, AP);
        nop();

        // reserved mode register select
        issue(K_LMR, 1'b1, 2'd2, 13'h000);
        nop();
        chk("R5 reserved bank code", err_flags, 6'h01);
        clr_pulse();

        // command with clock enable low
        issue(K_ACT, 1'b0, 2'd0, 13'd0);
        nop();
        chk("R12 cke low command flagged", err_flags, 6'h20);
        chk("R12 cke low command no effect", bank_open, 0);
        clr_pulse();
        nop();

        // self refresh and exit
        issue(K_REF, 1'b0, 2'd0, 13'd0);
        chk("R1 self refresh decode", cmd_onehot, 9'd128);
        issue(K_ACT, 1'b0, 2'd1, 13'd0);
        chk("R12 self refresh hides pins", cmd_onehot, 9'd1);
        issue(K_ACT, 1'b0, 2'd1, 13'd0);
        chk("R12 no flag in self refresh", err_flags, 0);
        chk("R12 no bank change in self refresh", bank_open, 0);
        issue(K_NOP, 1'b1, 2'd0, 13'd0);
        issue(K_ACT, 1'b1, 2'd0, 13'd1);
        issue(K_RD, 1'b1, 2'd0, 13'd0);
        nop();
        chk("R7 read soon after self refresh exit", err_flags, 6'h04);
        clr_pulse();
        issue(K_REF, 1'b1, 2'd0, 13'd0);
        chk("R1 auto refresh decode", cmd_onehot, 9'd64);
        issue(4'b1000, 1'b1, 2'd3, 13'h1FFF);
        chk("R1 deselect ignores pins", cmd_onehot, 9'd1);

        // set wins over clear, then stickiness
        issue(K_LMR, 1'b1, 2'd3, 13'h000);
        err_clr = 1'b1;
        nop();
        chk("R13 set beats clear", err_flags, 6'h01);
        repeat (3) nop();
        chk("R13 flag held", err_flags, 6'h01);
        clr_pulse();
        nop();
        chk("R13 flag cleared", err_flags, 0);

        // DLL disabled read
        issue(K_PRE, 1'b1, 2'd0, AP);
        issue(K_LMR, 1'b1, 2'd1, 13'h001);
        nop();
        chk("R5 dll disabled", dll_on, 0);
        issue(K_ACT, 1'b1, 2'd0, 13'd1);
        issue(K_RD, 1'b1, 2'd0, 13'd0);
        nop();
        chk("R7 read with dll off", err_flags, 6'h04);
        clr_pulse();

        // random decode phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            logic [3:0] code;
            code    = 4'($urandom());
            code[3] = (($urandom() % 4) == 0);
            issue(code, 1'b1, 2'($urandom()), 13'($urandom()));
            chk("R1 random decode", cmd_onehot, exp_oh(code, 1'b1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule